// File: doc/BRIEF.md
# Narrow-to-Wide Read Data Collector

This block sits on a read data return path, between a slave whose beats are narrower than the return channel and that 128-bit return channel. Each read burst is announced by a request carrying its beat size, the low bits of its start address and whether the transaction may be modified. These values are held for the whole burst. Slave beats then arrive with an ID, a response code and a last flag.

For a modifiable burst, the collector packs consecutive narrow beats into one wide word. A word is released when its top byte lane has been written, or when the burst's last beat arrives; in that case the partial word goes out with the last flag set. The wide beat carries the worst response code among the narrow beats it holds. For a non-modifiable burst, no packing takes place. Every narrow beat goes out on its own wide beat, in the byte lanes its address selects.

There is a single output word. While that word is waiting for the downstream side, the slave is held off. A new beat can be taken in the same cycle that the waiting word is accepted.

Top module: `rd_narrow_collector`

## Requirements
- R1: Out of reset, m_valid is 0, req_ready is 1 and s_ready is 0.
- R2: A request is accepted when req_valid and req_ready are both 1. After that, req_ready stays 0 until the output beat with m_last=1 has been accepted. While no request is active, s_ready is 0.
- R3: A beat of size code z (0..3) carries 2^z bytes in the low bytes of s_data; the other bytes of s_data are ignored. Its first output byte lane is req_addr rounded down to a multiple of 2^z. Each beat advances the lane by 2^z, and the lane wraps from 16 to 0.
- R4: For a modifiable burst, a wide word is emitted in the cycle after the beat that fills byte lane 15. The word holds every beat packed since the previous word, and any lane not written is 0.
- R5: For a modifiable burst, the beat with s_last=1 always releases the current word, even if it is partial, and that word has m_last=1. All earlier words of the burst have m_last=0.
- R6: For a non-modifiable burst, each slave beat produces exactly one output beat. That beat holds the slave beat's bytes in its lanes and 0 in every other lane, and its m_last and m_resp equal the beat's s_last and s_resp.
- R7: m_resp is the largest 2-bit code among the beats packed into the word, with the order OKAY=0 < EXOKAY=1 < SLVERR=2 < DECERR=3.
- R8: m_id equals the s_id of the beats that make up the word.
- R9: While m_valid is 1 and m_ready is 0, s_ready is 0, and m_valid, m_data and m_last hold their values into the next cycle.
- R10: In a cycle where m_valid and m_ready are both 1, s_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request presented |
| req_ready | output | 1 | Collector can take a request |
| req_size | input | 3 | Beat size code, bytes = 2^code |
| req_addr | input | OFF_W (4) | Low start-address bits |
| req_modifiable | input | 1 | 1 = pack beats, 0 = pass through |
| s_valid | input | 1 | Slave beat valid |
| s_ready | output | 1 | Collector takes slave beat |
| s_data | input | SLV_W (64) | Slave beat, right-aligned |
| s_id | input | ID_W (4) | Slave beat ID |
| s_resp | input | 2 | Slave beat response |
| s_last | input | 1 | Last beat of burst |
| m_valid | output | 1 | Wide beat valid |
| m_ready | input | 1 | Downstream accepts wide beat |
| m_data | output | OUT_W (128) | Wide beat data |
| m_id | output | ID_W (4) | Wide beat ID |
| m_resp | output | 2 | Merged response |
| m_last | output | 1 | Last wide beat of burst |

## Verification
The hardest case to reach is a slave beat that arrives in the same cycle a completed word is leaving, so that the new beat has to start a fresh, zeroed word. A close second is a word that has to hold its value over a run of stalls. The bench reaches both by driving m_ready from a pseudo-random sequence while slave beats stream in with occasional gaps. It replays unaligned start addresses, byte-sized beats that span two words, and bursts whose last beat lands mid-word. Every output beat is matched against a scoreboard entry that a byte-level model built from the requirements.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
   typedef logic [1:0] resp_t;

   function automatic resp_t resp_worse(input resp_t a, input resp_t b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rdc_ctx.sv
module rdc_ctx #(
   parameter int OUT_BYTES = 16,
   parameter int SLV_BYTES = 8,
   localparam int OFF_W    = $clog2(OUT_BYTES),
   localparam int MAX_SIZE = $clog2(SLV_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_take,
   input  logic [2:0]       req_size,
   input  logic [OFF_W-1:0] req_addr,
   input  logic             req_mod,
   input  logic             beat_take,
   output logic [OFF_W-1:0] offset,
   output logic [OFF_W:0]   nbytes,
   output logic             word_end,
   output logic             mod
);
   logic [2:0]       size_q;
   logic [OFF_W:0]   req_nb;
   logic [OFF_W-1:0] req_aligned;

   assign req_nb      = (OFF_W+1)'(1) << req_size;
   assign req_aligned = req_addr & ~(req_nb[OFF_W-1:0] - OFF_W'(1));
   assign nbytes      = (OFF_W+1)'(1) << size_q;
   assign word_end    = (({1'b0, offset} + nbytes) == (OFF_W+1)'(OUT_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q <= '0;
         mod    <= 1'b0;
         offset <= '0;
      end else if (req_take) begin
         size_q <= req_size;
         mod    <= req_mod;
         offset <= req_aligned;
      end else if (beat_take) begin
         offset <= offset + nbytes[OFF_W-1:0];
      end
   end

   assert_size_supported_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_take |-> (int'(req_size) <= MAX_SIZE));

   assert_lane_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      beat_take |-> ((offset & (nbytes[OFF_W-1:0] - OFF_W'(1))) == '0));
endmodule

// File: rtl/rdc_lane_merge.sv
module rdc_lane_merge #(
   parameter int OUT_BYTES = 16,
   parameter int SLV_BYTES = 8,
   localparam int OFF_W    = $clog2(OUT_BYTES),
   localparam int SIDX_W   = $clog2(SLV_BYTES)
) (
   input  logic [OUT_BYTES*8-1:0] cur,
   input  logic [SLV_BYTES*8-1:0] beat,
   input  logic [OFF_W-1:0]       offset,
   input  logic [OFF_W:0]         nbytes,
   output logic [OUT_BYTES*8-1:0] merged
);
   for (genvar j = 0; j < OUT_BYTES; j++) begin : g_lane
      logic [OFF_W:0] rel;
      logic           hit;
      assign rel = (OFF_W+1)'(j) - {1'b0, offset};
      assign hit = ({1'b0, offset} <= (OFF_W+1)'(j)) && (rel < nbytes);
      assign merged[8*j +: 8] = hit ? beat[8*rel[SIDX_W-1:0] +: 8] : cur[8*j +: 8];
   end
endmodule

// File: rtl/rdc_pack_buf.sv
module rdc_pack_buf
   import rdc_pkg::*;
#(
   parameter int OUT_W = 128,
   parameter int ID_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             mod,
   input  logic             word_end,
   input  logic             s_last,
   input  logic [ID_W-1:0]  s_id,
   input  resp_t            s_resp,
   input  logic [OUT_W-1:0] merged,
   input  logic             m_ready,
   output logic [OUT_W-1:0] cur_data,
   output logic             full,
   output logic [OUT_W-1:0] m_data,
   output logic [ID_W-1:0]  m_id,
   output resp_t            m_resp,
   output logic             m_last
);
   logic  pop;
   resp_t cur_resp;

   assign pop      = full && m_ready;
   assign cur_data = full ? '0 : m_data;
   assign cur_resp = full ? '0 : m_resp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full   <= 1'b0;
         m_data <= '0;
         m_id   <= '0;
         m_resp <= '0;
         m_last <= 1'b0;
      end else if (take) begin
         m_data <= merged;
         m_resp <= resp_worse(cur_resp, s_resp);
         m_id   <= s_id;
         m_last <= s_last;
         full   <= !mod || s_last || word_end;
      end else if (pop) begin
         full   <= 1'b0;
         m_data <= '0;
         m_resp <= '0;
         m_last <= 1'b0;
      end
   end

   assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !m_ready) |=> (full && $stable(m_data) && $stable(m_last)));

   assert_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !mod) |=> (full && (m_resp == $past(s_resp))));

   assert_flush_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && s_last) |=> (full && m_last));

   assert_resp_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (m_resp >= $past(s_resp)));
endmodule

// File: rtl/rd_narrow_collector.sv
module rd_narrow_collector
   import rdc_pkg::*;
#(
   parameter int OUT_W   = 128,
   parameter int SLV_W   = 64,
   parameter int ID_W    = 4,
   localparam int OFF_W  = $clog2(OUT_W/8)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_size,
   input  logic [OFF_W-1:0] req_addr,
   input  logic             req_modifiable,
   input  logic             s_valid,
   output logic             s_ready,
   input  logic [SLV_W-1:0] s_data,
   input  logic [ID_W-1:0]  s_id,
   input  logic [1:0]       s_resp,
   input  logic             s_last,
   output logic             m_valid,
   input  logic             m_ready,
   output logic [OUT_W-1:0] m_data,
   output logic [ID_W-1:0]  m_id,
   output logic [1:0]       m_resp,
   output logic             m_last
);
   localparam int OUT_BYTES = OUT_W / 8;
   localparam int SLV_BYTES = SLV_W / 8;

   if (OUT_W % 8 != 0 || SLV_W % 8 != 0) begin : g_bad_bytes
      $error("collector widths must be whole bytes");
   end
   if (SLV_W < 16 || SLV_W > OUT_W) begin : g_bad_ratio
      $error("slave width must lie between 16 bits and the output width");
   end
   if ((SLV_W & (SLV_W - 1)) != 0 || (OUT_W & (OUT_W - 1)) != 0) begin : g_bad_pow2
      $error("collector widths must be powers of two");
   end

   logic             busy;
   logic             req_take;
   logic             take;
   logic             pop;
   logic             full;
   logic             mod;
   logic             word_end;
   logic [OFF_W-1:0] offset;
   logic [OFF_W:0]   nbytes;
   logic [OUT_W-1:0] cur_data;
   logic [OUT_W-1:0] merged;

   assign req_ready = !busy;
   assign req_take  = req_valid && req_ready;
   assign s_ready   = busy && (!full || m_ready);
   assign take      = s_valid && s_ready;
   assign m_valid   = full;
   assign pop       = full && m_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)              busy <= 1'b0;
      else if (req_take)       busy <= 1'b1;
      else if (pop && m_last)  busy <= 1'b0;
   end

   rdc_ctx #(.OUT_BYTES(OUT_BYTES), .SLV_BYTES(SLV_BYTES)) u_ctx (
      .clk(clk), .rst_n(rst_n), .req_take(req_take), .req_size(req_size),
      .req_addr(req_addr), .req_mod(req_modifiable), .beat_take(take),
      .offset(offset), .nbytes(nbytes), .word_end(word_end), .mod(mod)
   );

   rdc_lane_merge #(.OUT_BYTES(OUT_BYTES), .SLV_BYTES(SLV_BYTES)) u_merge (
      .cur(cur_data), .beat(s_data), .offset(offset), .nbytes(nbytes),
      .merged(merged)
   );

   rdc_pack_buf #(.OUT_W(OUT_W), .ID_W(ID_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .take(take), .mod(mod), .word_end(word_end),
      .s_last(s_last), .s_id(s_id), .s_resp(s_resp), .merged(merged),
      .m_ready(m_ready), .cur_data(cur_data), .full(full), .m_data(m_data),
      .m_id(m_id), .m_resp(m_resp), .m_last(m_last)
   );

   assert_req_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_take |=> !req_ready);

   assert_no_take_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |-> !(s_valid && s_ready));
endmodule

// File: tb/tb_rd_narrow_collector.sv
module tb_rd_narrow_collector;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [2:0]   req_size = '0;
   logic [3:0]   req_addr = '0;
   logic         req_modifiable = 1'b0;
   logic         s_valid = 1'b0;
   logic         s_ready;
   logic [63:0]  s_data = '0;
   logic [3:0]   s_id = '0;
   logic [1:0]   s_resp = '0;
   logic         s_last = 1'b0;
   logic         m_valid;
   logic         m_ready = 1'b1;
   logic [127:0] m_data;
   logic [3:0]   m_id;
   logic [1:0]   m_resp;
   logic         m_last;

   rd_narrow_collector dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [127:0] data;
      logic [3:0]   id;
      logic [1:0]   resp;
      logic         last;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   int errors = 0;
   int checks = 0;
   int bn = 0;
   bit rnd_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit hold_pend = 0;
   logic [127:0] hold_data;
   logic hold_last;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int b, input int i, input int k);
      return 8'((b * 29 + i * 7 + k * 3 + 1) & 255);
   endfunction

   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = rnd_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
   end

   // Scoreboard monitor, sampled mid-cycle.
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend) begin
            check(m_valid === 1'b1 && m_data === hold_data && m_last === hold_last,
                  "R9", "output held over stall", m_data, hold_data);
         end
         hold_pend = 0;
         if (m_valid && !m_ready) begin
            check(s_ready === 1'b0, "R9", "s_ready during stall", 128'(s_ready), 128'(0));
            hold_pend = 1;
            hold_data = m_data;
            hold_last = m_last;
         end
         if (m_valid && m_ready) begin
            check(s_ready === 1'b1, "R10", "s_ready on accept", 128'(s_ready), 128'(1));
            if (exp_q.size() == 0) begin
               check(0, "R4", "unexpected output beat", m_data, 128'(0));
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(m_data === e.data, e.tag, "data", m_data, e.data);
               check(m_id === e.id, "R8", "id", 128'(m_id), 128'(e.id));
               check(m_resp === e.resp, "R7", "resp", 128'(m_resp), 128'(e.resp));
               check(m_last === e.last, "R5", "last", 128'(m_last), 128'(e.last));
            end
         end
      end
   end

   task automatic run_burst(input bit mod, input int size, input int addr, input int len,
                            input logic [3:0] id, input logic [31:0] rpat, input bit gap);
      int nb;
      int off;
      logic [127:0] w;
      logic [1:0] r;
      logic [1:0] rv;
      nb = 1 << size;
      off = (addr & 15) & ~(nb - 1);
      w = '0;
      r = '0;
      for (int i = 0; i < len; i++) begin
         rv = rpat[2*(i%16) +: 2];
         for (int k = 0; k < nb; k++) w[8*(off+k) +: 8] = pat(bn, i, k);
         if (rv > r) r = rv;
         off += nb;
         if (!mod || i == len - 1 || off == 16) begin
            exp_t e;
            e.data = w;
            e.id = id;
            e.resp = r;
            e.last = (i == len - 1);
            e.tag = mod ? "R3 R4 R5" : "R3 R6";
            exp_q.push_back(e);
            w = '0;
            r = '0;
         end
         off = off % 16;
      end
      // R2: idle collector refuses slave beats.
      @(negedge clk);
      check(s_ready === 1'b0, "R2", "s_ready while idle", 128'(s_ready), 128'(0));
      @(posedge clk); #1;
      req_valid = 1'b1;
      req_size = 3'(size);
      req_addr = 4'(addr);
      req_modifiable = mod;
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      check(req_ready === 1'b0, "R2", "req_ready during burst", 128'(req_ready), 128'(0));
      @(posedge clk); #1;
      for (int i = 0; i < len; i++) begin
         logic [63:0] d;
         if (gap && (i % 3 == 1)) begin
            s_valid = 1'b0;
            @(posedge clk); #1;
         end
         d = {8{8'hA5}};
         for (int k = 0; k < nb; k++) d[8*k +: 8] = pat(bn, i, k);
         s_valid = 1'b1;
         s_data = d;
         s_id = id;
         s_resp = rpat[2*(i%16) +: 2];
         s_last = (i == len - 1);
         do @(negedge clk); while (s_ready !== 1'b1);
         @(posedge clk); #1;
      end
      s_valid = 1'b0;
      s_last = 1'b0;
      wait (exp_q.size() == 0);
      @(negedge clk);
      @(negedge clk);
      check(req_ready === 1'b1, "R2", "req_ready after burst", 128'(req_ready), 128'(1));
      bn++;
   endtask

   task automatic suite(input bit gap);
      run_burst(1, 3, 0, 4, 4'h1, 32'h0, gap);
      run_burst(1, 2, 0, 8, 4'h2, 32'h0000_0080, gap);
      run_burst(1, 2, 4, 5, 4'h3, 32'h0000_0124, gap);
      run_burst(0, 2, 8, 4, 4'h4, 32'h0000_00E4, gap);
      run_burst(1, 3, 8, 1, 4'h5, 32'h0000_0003, gap);
      run_burst(1, 0, 3, 20, 4'h6, 32'h0100_0010, gap);
      run_burst(0, 3, 5, 3, 4'h7, 32'h0000_0021, gap);
      run_burst(1, 1, 6, 9, 4'h8, 32'h0000_4000, gap);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(m_valid === 1'b0 && req_ready === 1'b1 && s_ready === 1'b0, "R1",
            "reset state", {125'd0, m_valid, req_ready, s_ready}, 128'b010);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(m_valid === 1'b0 && req_ready === 1'b1 && s_ready === 1'b0, "R1",
            "after reset", {125'd0, m_valid, req_ready, s_ready}, 128'b010);
      suite(0);
      rnd_mode = 1;
      suite(0);
      suite(1);
      for (int t = 0; t < 12; t++) begin
         run_burst(t % 3 != 0, t % 4, (t * 5) % 16, 2 + (t * 3) % 11, 4'(t),
                   32'(t * 32'h9E37_79B9), t[0]);
      end
      repeat (5) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule